// File: doc/BRIEF.md
# Flash Write-Status Reporter

This block is the device-side logic of a two-bank flash part that tells the host how an internal program or erase is getting on. A command decoder, which is outside this block, issues a one-cycle start pulse once the final write strobe of a command sequence has been accepted. That pulse carries the operation kind, the target address and, for a program, the data word. A cycle timer, also outside the block, ends the operation with a one-cycle done pulse. While the operation runs, host reads that land in a busy bank get a status word instead of array contents. In that word one bit is the inverted data bit, or zero for an erase, and a second bit flips on every read. Reads to the other bank keep returning array data, so the host can run code from one bank while it rewrites the other.

The block also drives a ready/busy line in open-drain style, which pulls low only while an operation runs. It qualifies a reset pin: a pulse that is held long enough aborts the operation and puts the part back in array-read mode. A small model of both banks keeps array reads meaningful. Each bank is modelled by a few words, indexed by the low address bits. A program can only clear bits, and an erase sets the modelled words back to all ones.

Top module: `fsr_status_unit`

## Requirements
- R1: An address whose two top bits (19:18) equal the `BANK_SEL` parameter (default 2'b11) belongs to the small bank; every other address belongs to the large bank. Inside a bank the array model is indexed by address bits [IDX_W-1:0] (default 3 bits).
- R2: While a program runs (kind 0), a strobed read to its bank returns the array word at that address, with bit 7 replaced by the inverse of bit 7 of the word being programmed and bit 6 replaced by the toggle state.
- R3: While any erase runs (kind 1 sector, 2 block, 3 chip), a strobed read to a busy bank returns bit 7 as 0 and bit 6 as the toggle state. All other bits are the array word.
- R4: The toggle state is 0 at each accepted start. It inverts after each strobed read to a busy bank. Reads to an idle bank leave it unchanged, and it stays still once the operation ends.
- R5: A strobed read to a bank that is not busy, or any read while idle, returns the plain array word.
- R6: `busy_pull` is 1 from the clock edge that accepts a start until the edge that takes the done pulse. It is 0 at any time `ce_n` is high or `hw_rst_n` is low.
- R7: On done, a program ANDs its word into the addressed model word. A sector or block erase sets every model word of the target bank to 16'hFFFF. A chip erase (both banks busy) sets every model word of both banks to 16'hFFFF.
- R8: A start pulse while an operation runs is ignored, as is a start while `hw_rst_n` is low. A done pulse while idle is ignored.
- R9: If `hw_rst_n` is sampled low on `RST_MIN_CYC` consecutive edges (default 4), the block aborts: busy clears and the array is left unchanged. A shorter low pulse has no effect on the operation.
- R10: Synchronous reset leaves the block idle, with `busy_pull` 0, `rd_data` 0 and every model word 16'hFFFF.
- R11: `rd_data` updates only on the clock edge where `rd_strobe` is high, using the state before that edge. Without a strobe it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle pulse: the command's final write strobe was accepted |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| op_addr | input | 20 | Target word address of the operation |
| op_word | input | 16 | Word to program (ignored for erases) |
| op_done | input | 1 | One-cycle pulse from the cycle timer ending the operation |
| rd_strobe | input | 1 | Read request, one per host read |
| rd_addr | input | 20 | Read address |
| rd_data | output | 16 | Read result, registered |
| ce_n | input | 1 | Chip enable, active low |
| hw_rst_n | input | 1 | Reset pin, active low, width-qualified |
| busy_pull | output | 1 | 1 = ready/busy line actively pulled low; 0 = released (high impedance) |

## Verification
On every cycle the assertions track the status bits of a strobed read to a busy bank: the inverted or zero bit 7 and the toggle that flips or holds. They also check that a start pulse arriving during an operation leaves the latched operation as it was, that a qualified reset pulse clears busy, and that erase and program commits leave the array words they should. Several behaviours show up only in the bench's scenarios. These are the full contents of idle-bank reads during an operation, the toggle restarting at 0 for a new operation, the short-versus-long reset pulse difference, and the gating of the busy line by chip enable.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int FSR_AW = 20;
    localparam int FSR_DW = 16;
    localparam int DQ_POLL_BIT = 7;
    localparam int DQ_TOG_BIT  = 6;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic [FSR_AW-1:0]   addr;
        logic [FSR_DW-1:0]   word;
    } op_desc_t;

    // 1 = small bank, 0 = large bank
    function automatic logic bank_of(input logic [FSR_AW-1:0] a, input logic [1:0] sel);
        return a[FSR_AW-1 -: 2] == sel;
    endfunction

    // bit 1 = small bank busy, bit 0 = large bank busy
    function automatic logic [1:0] busy_banks(input op_kind_e k,
                                              input logic [FSR_AW-1:0] a,
                                              input logic [1:0] sel);
        logic [1:0] m;
        if (k == OP_CHIP)       m = 2'b11;
        else if (bank_of(a, sel)) m = 2'b10;
        else                    m = 2'b01;
        return m;
    endfunction

    function automatic logic [FSR_DW-1:0] status_word(input logic [FSR_DW-1:0] arr,
                                                      input op_kind_e k,
                                                      input logic wbit,
                                                      input logic tog);
        logic [FSR_DW-1:0] s;
        s = arr;
        s[DQ_POLL_BIT] = (k == OP_PROG) ? ~wbit : 1'b0;
        s[DQ_TOG_BIT]  = tog;
        return s;
    endfunction

endpackage

// File: rtl/fsr_rst_filter.sv
module fsr_rst_filter #(
    parameter int MIN_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hw_rst_n,
    output logic abort
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(MIN_CYC - 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst)              low_cnt <= '0;
        else if (hw_rst_n)    low_cnt <= '0;
        else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
    end

    assign abort = !hw_rst_n && (low_cnt == LIM);

    // R9: once qualified, the abort persists for as long as the pin stays low
    hold_qual_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> (abort || hw_rst_n));

endmodule

// File: rtl/fsr_op_tracker.sv
module fsr_op_tracker
    import fsr_pkg::*;
#(
    parameter logic [1:0] BANK_SEL = 2'b11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  op_desc_t            req,
    input  logic                done,
    input  logic                abort,
    input  logic                pin_low,
    input  logic                rd_strobe,
    input  logic [FSR_AW-1:0]   rd_addr,
    output logic                busy,
    output op_desc_t            cur,
    output logic [1:0]          bmask,
    output logic                toggle,
    output logic                commit,
    output logic                rd_hit
);
    logic accept;

    assign accept = start && !busy && !abort && !pin_low;
    assign commit = done && busy && !abort;
    assign bmask  = busy_banks(cur.kind, cur.addr, BANK_SEL);
    assign rd_hit = rd_strobe && busy && bmask[bank_of(rd_addr, BANK_SEL)];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= '0;
        end else if (abort) begin
            busy <= 1'b0;
        end else if (accept) begin
            busy <= 1'b1;
            cur  <= req;
        end else if (commit) begin
            busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          toggle <= 1'b0;
        else if (accept)  toggle <= 1'b0;
        else if (rd_hit)  toggle <= ~toggle;
    end

    // R4
    toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> toggle != $past(toggle));

    // R4
    toggle_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(toggle));

    // R8
    ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !abort && !done) |=> (busy && cur == $past(cur)));

    // R9
    abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> !busy);

    // R8
    idle_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && done) |=> !busy);

endmodule

// File: rtl/fsr_array_model.sv
module fsr_array_model
    import fsr_pkg::*;
#(
    parameter int         IDX_W    = 3,
    parameter logic [1:0] BANK_SEL = 2'b11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                commit,
    input  op_desc_t            cur,
    input  logic [1:0]          bmask,
    input  logic [FSR_AW-1:0]   rd_addr,
    output logic [FSR_DW-1:0]   rd_word
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int NBANK = 2;

    logic [FSR_DW-1:0] bank_rd [NBANK];
    logic [IDX_W-1:0]  wr_idx;
    logic              wr_bank;

    assign wr_idx  = cur.addr[IDX_W-1:0];
    assign wr_bank = bank_of(cur.addr, BANK_SEL);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [FSR_DW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
            end else if (commit) begin
                if (cur.kind == OP_PROG) begin
                    if (wr_bank == 1'(b)) mem[wr_idx] <= mem[wr_idx] & cur.word;
                end else if (bmask[b]) begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                end
            end
        end

        assign bank_rd[b] = mem[rd_addr[IDX_W-1:0]];

        // R7
        erase_fill_chk: assert property (@(posedge clk) disable iff (rst)
            (commit && cur.kind != OP_PROG && bmask[b])
                |=> (mem[0] == '1 && mem[DEPTH-1] == '1));

        // R7
        prog_and_chk: assert property (@(posedge clk) disable iff (rst)
            (commit && cur.kind == OP_PROG && wr_bank == 1'(b))
                |=> mem[$past(wr_idx)] == ($past(mem[wr_idx]) & $past(cur.word)));
    end

    // R1: read port selects the bank from the top address bits
    assign rd_word = bank_rd[bank_of(rd_addr, BANK_SEL)];

endmodule

// File: rtl/fsr_status_unit.sv
module fsr_status_unit
    import fsr_pkg::*;
#(
    parameter int         IDX_W       = 3,
    parameter logic [1:0] BANK_SEL    = 2'b11,
    parameter int         RST_MIN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [19:0]       op_addr,
    input  logic [15:0]       op_word,
    input  logic              op_done,
    input  logic              rd_strobe,
    input  logic [19:0]       rd_addr,
    output logic [15:0]       rd_data,
    input  logic              ce_n,
    input  logic              hw_rst_n,
    output logic              busy_pull
);
    op_desc_t          req;
    op_desc_t          cur;
    logic              abort;
    logic              busy;
    logic [1:0]        bmask;
    logic              toggle;
    logic              commit;
    logic              rd_hit;
    logic [FSR_DW-1:0] arr_word;

    assign req = '{kind: op_kind_e'(op_kind), addr: op_addr, word: op_word};

    fsr_rst_filter #(.MIN_CYC(RST_MIN_CYC)) i_filter (
        .clk      (clk),
        .rst      (rst),
        .hw_rst_n (hw_rst_n),
        .abort    (abort)
    );

    fsr_op_tracker #(.BANK_SEL(BANK_SEL)) i_tracker (
        .clk       (clk),
        .rst       (rst),
        .start     (op_start),
        .req       (req),
        .done      (op_done),
        .abort     (abort),
        .pin_low   (!hw_rst_n),
        .rd_strobe (rd_strobe),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .cur       (cur),
        .bmask     (bmask),
        .toggle    (toggle),
        .commit    (commit),
        .rd_hit    (rd_hit)
    );

    fsr_array_model #(.IDX_W(IDX_W), .BANK_SEL(BANK_SEL)) i_array (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .cur      (cur),
        .bmask    (bmask),
        .rd_addr  (rd_addr),
        .rd_word  (arr_word)
    );

    always_ff @(posedge clk) begin
        if (rst)            rd_data <= '0;
        else if (rd_strobe) rd_data <= rd_hit
                                       ? status_word(arr_word, cur.kind, cur.word[DQ_POLL_BIT], toggle)
                                       : arr_word;
    end

    assign busy_pull = busy && !ce_n && hw_rst_n;

    // R2
    prog_poll_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && cur.kind == OP_PROG) |=> rd_data[DQ_POLL_BIT] == !$past(cur.word[DQ_POLL_BIT]));

    // R3
    erase_poll_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && cur.kind != OP_PROG) |=> rd_data[DQ_POLL_BIT] == 1'b0);

    // R5
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !busy) |=> rd_data == $past(arr_word));

    // R11
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(rd_data));

    // R6
    pin_release_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n || !hw_rst_n || !busy) |-> !busy_pull);

endmodule

// File: tb/test_fsr_status_unit.sv
module test_fsr_status_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_start = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [19:0] op_addr = '0;
    logic [15:0] op_word = '0;
    logic        op_done = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [19:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic        ce_n = 1'b0;
    logic        hw_rst_n = 1'b1;
    logic        busy_pull;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    fsr_status_unit i_fsr_status_unit (
        .clk       (clk),
        .rst       (rst),
        .op_start  (op_start),
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .op_word   (op_word),
        .op_done   (op_done),
        .rd_strobe (rd_strobe),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ce_n      (ce_n),
        .hw_rst_n  (hw_rst_n),
        .busy_pull (busy_pull)
    );

    localparam logic [1:0] A_RD = 2'd0;
    localparam logic [1:0] A_ST = 2'd1;
    localparam logic [1:0] A_DN = 2'd2;

    typedef struct packed {
        logic [1:0]  act;
        logic [1:0]  op;
        logic [19:0] addr;
        logic [15:0] dat;
        logic        bsy;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t v(input logic [1:0] act, input logic [1:0] op,
                               input logic [19:0] addr, input logic [15:0] dat,
                               input logic bsy, input logic [3:0] req);
        return '{act: act, op: op, addr: addr, dat: dat, bsy: bsy, req: req};
    endfunction

    localparam int NV = 39;
    localparam vec_t TBL [NV] = '{
        v(A_RD, 2'd0, 20'h00003, 16'hFFFF, 1'b0, 4'd10), // R10 erased array after reset
        v(A_ST, 2'd0, 20'h00003, 16'h1234, 1'b1, 4'd6),  // R6 program starts
        v(A_RD, 2'd0, 20'h00003, 16'hFFBF, 1'b1, 4'd2),  // R2 bit7 inverted, toggle 0
        v(A_RD, 2'd0, 20'h00003, 16'hFFFF, 1'b1, 4'd4),  // R4 toggle now 1
        v(A_RD, 2'd0, 20'hC0005, 16'hFFFF, 1'b1, 4'd5),  // R5 idle small bank
        v(A_RD, 2'd0, 20'h00003, 16'hFFBF, 1'b1, 4'd4),  // R4 idle-bank read left toggle
        v(A_DN, 2'd0, 20'h00000, 16'h0000, 1'b0, 4'd6),
        v(A_RD, 2'd0, 20'h00003, 16'h1234, 1'b0, 4'd7),  // R7 program committed
        v(A_RD, 2'd0, 20'h00003, 16'h1234, 1'b0, 4'd4),  // R4 no status after done
        v(A_ST, 2'd1, 20'hC0005, 16'h0000, 1'b1, 4'd6),  // sector erase small bank
        v(A_RD, 2'd0, 20'hC0001, 16'hFF3F, 1'b1, 4'd3),  // R3 bit7 0, toggle 0
        v(A_RD, 2'd0, 20'h00003, 16'h1234, 1'b1, 4'd1),  // R1 large bank idle
        v(A_RD, 2'd0, 20'hC0001, 16'hFF7F, 1'b1, 4'd3),  // R3 toggle 1
        v(A_ST, 2'd0, 20'h00003, 16'h0000, 1'b1, 4'd8),  // R8 start while busy
        v(A_DN, 2'd0, 20'h00000, 16'h0000, 1'b0, 4'd6),
        v(A_RD, 2'd0, 20'h00003, 16'h1234, 1'b0, 4'd8),  // R8 ignored start wrote nothing
        v(A_ST, 2'd0, 20'hC0002, 16'h5A80, 1'b1, 4'd6),
        v(A_RD, 2'd0, 20'hC0002, 16'hFF3F, 1'b1, 4'd2),  // R2 word bit7=1 -> read 0
        v(A_DN, 2'd0, 20'h00000, 16'h0000, 1'b0, 4'd6),
        v(A_RD, 2'd0, 20'hC0002, 16'h5A80, 1'b0, 4'd7),
        v(A_ST, 2'd3, 20'h00000, 16'h0000, 1'b1, 4'd6),  // chip erase
        v(A_RD, 2'd0, 20'h00003, 16'h1234, 1'b1, 4'd4),  // R4 toggle restarted at 0
        v(A_RD, 2'd0, 20'hC0002, 16'h5A40, 1'b1, 4'd3),  // R3 both banks busy
        v(A_DN, 2'd0, 20'h00000, 16'h0000, 1'b0, 4'd6),
        v(A_RD, 2'd0, 20'h00003, 16'hFFFF, 1'b0, 4'd7),
        v(A_RD, 2'd0, 20'hC0002, 16'hFFFF, 1'b0, 4'd7),
        v(A_DN, 2'd0, 20'h00000, 16'h0000, 1'b0, 4'd8),  // R8 done while idle
        v(A_RD, 2'd0, 20'h00003, 16'hFFFF, 1'b0, 4'd8),
        v(A_ST, 2'd0, 20'h00004, 16'h00F0, 1'b1, 4'd6),
        v(A_DN, 2'd0, 20'h00000, 16'h0000, 1'b0, 4'd6),
        v(A_RD, 2'd0, 20'h00004, 16'h00F0, 1'b0, 4'd7),
        v(A_ST, 2'd2, 20'h00000, 16'h0000, 1'b1, 4'd6),  // block erase large bank
        v(A_RD, 2'd0, 20'h00004, 16'h0030, 1'b1, 4'd3),
        v(A_DN, 2'd0, 20'h00000, 16'h0000, 1'b0, 4'd6),
        v(A_RD, 2'd0, 20'h00004, 16'hFFFF, 1'b0, 4'd7),
        v(A_ST, 2'd0, 20'h00004, 16'hF0FF, 1'b1, 4'd6),
        v(A_DN, 2'd0, 20'h00000, 16'h0000, 1'b0, 4'd6),
        v(A_ST, 2'd0, 20'h00004, 16'h0FFF, 1'b1, 4'd6),
        v(A_DN, 2'd0, 20'h00000, 16'h0000, 1'b0, 4'd6)
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input vec_t e);
        @(negedge clk);
        case (e.act)
            A_ST: begin op_start = 1'b1; op_kind = e.op; op_addr = e.addr; op_word = e.dat; end
            A_DN: op_done = 1'b1;
            default: begin rd_strobe = 1'b1; rd_addr = e.addr; end
        endcase
        @(posedge clk);
        #1;
        op_start = 1'b0; op_done = 1'b0; rd_strobe = 1'b0;
        if (e.act == A_RD)
            chk(rd_data == e.dat, $sformatf("R%0d read", e.req), 32'(rd_data), 32'(e.dat));
        chk(busy_pull == e.bsy, "R6 busy line", 32'(busy_pull), 32'(e.bsy));
    endtask

    task automatic rd(input logic [19:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        rd_strobe = 1'b1; rd_addr = a;
        @(posedge clk);
        #1;
        rd_strobe = 1'b0;
        chk(rd_data == exp, tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic pin_low(input int n);
        @(negedge clk);
        hw_rst_n = 1'b0;
        repeat (n) @(posedge clk);
        #1;
        chk(busy_pull == 1'b0, "R6 line released during pin reset", 32'(busy_pull), 32'd0);
        @(negedge clk);
        hw_rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R10: reset state
        chk(busy_pull == 1'b0, "R10 busy after reset", 32'(busy_pull), 32'd0);
        chk(rd_data == 16'h0, "R10 rd_data after reset", 32'(rd_data), 32'd0);

        for (int i = 0; i < NV; i++) step(TBL[i]);
        // R7 program only clears bits: F0FF & 0FFF
        rd(20'h00004, 16'h00FF, "R7 program ANDs into word");

        // R6: chip enable gates the busy line
        step(v(A_ST, 2'd0, 20'h00006, 16'h0000, 1'b1, 4'd6));
        @(negedge clk); ce_n = 1'b1; #1;
        chk(busy_pull == 1'b0, "R6 ce_n high releases line", 32'(busy_pull), 32'd0);
        @(negedge clk); ce_n = 1'b0; #1;
        chk(busy_pull == 1'b1, "R6 ce_n low pulls line", 32'(busy_pull), 32'd1);

        // R9: short pin pulse keeps the operation
        pin_low(3);
        #1;
        chk(busy_pull == 1'b1, "R9 short pulse no abort", 32'(busy_pull), 32'd1);
        rd(20'h00006, 16'hFFBF, "R9 still busy after short pulse");

        // R9: qualified pulse aborts, array untouched
        pin_low(4);
        #1;
        chk(busy_pull == 1'b0, "R9 long pulse aborts", 32'(busy_pull), 32'd0);
        rd(20'h00006, 16'hFFFF, "R9 array read mode after abort");
        step(v(A_DN, 2'd0, 20'h00000, 16'h0000, 1'b0, 4'd9));
        rd(20'h00006, 16'hFFFF, "R9 aborted program never committed");

        // R8: start while pin low is ignored
        @(negedge clk); hw_rst_n = 1'b0;
        op_start = 1'b1; op_kind = 2'd0; op_addr = 20'h00007; op_word = 16'h0000;
        @(posedge clk); #1; op_start = 1'b0;
        @(negedge clk); hw_rst_n = 1'b1; #1;
        chk(busy_pull == 1'b0, "R8 start during pin reset ignored", 32'(busy_pull), 32'd0);

        // R11: no strobe, data holds while address changes
        @(negedge clk); rd_addr = 20'hC0002;
        @(posedge clk); #1;
        chk(rd_data == 16'hFFFF, "R11 hold without strobe", 32'(rd_data), 32'hFFFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule